// File: doc/BRIEF.md
# DMA Channel Trigger Selector

This block decides when each of two fly-by DMA channels starts a transfer. Channel 1 can be started by one of seven hardware event lines. A 4-bit select code from the system configuration register picks the line. Channel 2 listens only to the second serial port. Both channels can also be started by a software strobe. Every hardware line is a level-type interrupt, and the block turns a rising edge on the selected line into a single one-cycle request.

Each channel has a run bit. While the run bit is low the channel is in program mode. In that mode every trigger, hardware or software, is thrown away and never stored. A request is registered together with a direction flag, which tells the transfer engine whether the event was a transmit or a receive. For the second serial port the flag follows which of that port's two interrupts is raised.

Top module: `dma_trig_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both request outputs and both direction outputs are 0. All outputs are registered, so a request appears in the cycle after the qualifying input edge. A line that is already high when reset is released produces no request until it falls and rises again.
- R2: With the channel 1 select code at 0011, 0101, 0111, 1001, 1011, 1101 or 1111, a rising edge on the matching source raises `ch1_req` for one cycle. The matching sources are: serial port 2 (tx or rx), tick unit 1 timer A, serial port 1 rx, RF PLL lock, external interrupt 2, tick unit 2 timer A, and serial port 1 tx. The bit positions of `irq_i` are 0 serial port 2 tx, 1 serial port 2 rx, 2 tick unit 1 timer A, 3 serial port 1 rx, 4 PLL lock, 5 external interrupt 2, 6 tick unit 2 timer A, 7 serial port 1 tx.
- R3: Every other select code (all even codes and 0001) selects no source, so `ch1_req` never rises from hardware. Edges on sources that are not selected are also ignored.
- R4: `ch2_req` follows only rising edges of serial port 2 activity (bit 0 OR bit 1), whatever the select code is.
- R5: A source held high gives exactly one request pulse, and a new pulse needs the source to fall and rise again.
- R6: While a channel's run bit is 0, that channel issues no request of any kind. Triggers that arrive in that time are discarded, so raising the run bit while a source is already high does not produce a request.
- R7: A one-cycle software strobe `sw_go_i[0]` (channel 1) or `sw_go_i[1]` (channel 2) in a running channel gives one request in the next cycle, with direction 0.
- R8: Changing the select code never produces a request by itself, even if the newly selected source is already high.
- R9: A direction output is 1 only together with a hardware request for a transmit event. For channel 1 that means code 1111, or code 0011 with bit 0 high. For channel 2 it means bit 0 high. When both serial port 2 bits are high, transmit wins. In every other cycle the direction output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch1_src_sel_i | input | 4 | Channel 1 source select code |
| ch1_run_i | input | 1 | Channel 1 run bit (0 = program mode) |
| ch2_run_i | input | 1 | Channel 2 run bit (0 = program mode) |
| irq_i | input | 8 | Level interrupt lines, bit order as in R2 |
| sw_go_i | input | 2 | Software strobes, bit 0 channel 1, bit 1 channel 2 |
| ch1_req_o | output | 1 | Channel 1 one-cycle transfer request |
| ch1_dir_tx_o | output | 1 | Channel 1 request is a transmit event |
| ch2_req_o | output | 1 | Channel 2 one-cycle transfer request |
| ch2_dir_tx_o | output | 1 | Channel 2 request is a transmit event |

## Verification
The only state inside the block is the edge-history register of each lane and the output register of each channel. If an edge-history bit is wrong, the result shows at the ports in the very next cycle. A history bit that is stuck at 0 shows up as a second pulse from a held source. A history bit that is stuck at 1 shows up as a missing pulse. For that reason every vector first drops all lines, then raises the stimulus, and checks both channels one cycle later. A select decode or a run gate that is wrong shows up as a request, or a direction bit, on the wrong channel in that same cycle.

// File: rtl/dma_trig_pkg.sv
// Shared constants for the DMA trigger selector: interrupt bit order,
// edge-lane order and channel 1 select codes.
package dma_trig_pkg;
    // Width of the raw interrupt bus.
    localparam int IRQ_W      = 8;
    // Width of the channel 1 select code.
    localparam int SEL_W      = 4;

    // Positions of the raw interrupt lines.
    localparam int IRQ_U2_TX  = 0;
    localparam int IRQ_U2_RX  = 1;
    localparam int IRQ_TICK1A = 2;
    localparam int IRQ_U1_RX  = 3;
    localparam int IRQ_PLL    = 4;
    localparam int IRQ_EXT2   = 5;
    localparam int IRQ_TICK2A = 6;
    localparam int IRQ_U1_TX  = 7;

    // Edge lanes: the serial port 2 pair shares one lane.
    localparam int LANES      = IRQ_W - 1;
    localparam int LN_U2      = 0;
    localparam int LN_TICK1A  = 1;
    localparam int LN_U1_RX   = 2;
    localparam int LN_PLL     = 3;
    localparam int LN_EXT2    = 4;
    localparam int LN_TICK2A  = 5;
    localparam int LN_U1_TX   = 6;

    // Channel 1 select codes; the lane order follows the code order.
    typedef enum logic [SEL_W-1:0] {
        SEL_U2     = 4'b0011,
        SEL_TICK1A = 4'b0101,
        SEL_U1_RX  = 4'b0111,
        SEL_PLL    = 4'b1001,
        SEL_EXT2   = 4'b1011,
        SEL_TICK2A = 4'b1101,
        SEL_U1_TX  = 4'b1111
    } ch1_sel_e;
endpackage

// File: rtl/dma_trig_edge.sv
// Rising-edge detector bank.
// Each lane keeps its previous level. A lane reports an edge when it is
// high now and was low in the previous cycle. Every history bit resets to 1,
// so a line that is already high when reset is released cannot fire.
// Assumes the inputs are synchronous to clk.
module dma_trig_edge #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] hist_q;

    for (genvar g = 0; g < W; g++) begin : g_lane
        // Remember the previous level of this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[g] <= 1'b1;
            else        hist_q[g] <= lvl_i[g];
        end

        // Report an edge: high now, low in the previous cycle.
        always_comb rise_o[g] = lvl_i[g] & ~hist_q[g];

        // R5: history tracks the previous cycle's level, so a held line cannot re-fire.
        a_r5_hist_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> hist_q[g] == $past(lvl_i[g]));
    end
endmodule

// File: rtl/dma_trig_ch1_mux.sv
// Channel 1 source selector.
// The sparse odd select code picks one edge lane. Unlisted codes pick
// nothing. The serial port 2 lane takes its direction from whether that
// port's tx interrupt is raised. Purely combinational apart from the
// assertion clock.
module dma_trig_ch1_mux
    import dma_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [LANES-1:0] rise_i,
    input  logic             u2_tx_lvl_i,
    output logic             hit_o,
    output logic             dir_tx_o
);
    logic [LANES-1:0] pick;

    // One-hot decode of the select code onto the edge lanes.
    always_comb begin
        pick = '0;
        case (sel_i)
            SEL_U2:     pick[LN_U2]     = 1'b1;
            SEL_TICK1A: pick[LN_TICK1A] = 1'b1;
            SEL_U1_RX:  pick[LN_U1_RX]  = 1'b1;
            SEL_PLL:    pick[LN_PLL]    = 1'b1;
            SEL_EXT2:   pick[LN_EXT2]   = 1'b1;
            SEL_TICK2A: pick[LN_TICK2A] = 1'b1;
            SEL_U1_TX:  pick[LN_U1_TX]  = 1'b1;
            default:    pick            = '0;
        endcase
    end

    // Merge the picked edge and derive its direction.
    always_comb begin
        hit_o    = |(pick & rise_i);
        dir_tx_o = (pick[LN_U1_TX] & rise_i[LN_U1_TX])
                 | (pick[LN_U2] & rise_i[LN_U2] & u2_tx_lvl_i);
    end

    // R3: even codes and 0001 never produce a hardware hit.
    a_r3_unlisted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i[0] || sel_i == 4'b0001) |-> !hit_o);

    // R2: at most one lane is ever picked.
    a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

    // R9: a transmit direction only comes with a hit.
    a_r9_dir_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx_o |-> hit_o);
endmodule

// File: rtl/dma_trig_chan.sv
// One DMA channel's trigger gate.
// Merges the hardware hit with the software strobe, gates the result with
// the run bit and registers it as a one-cycle request plus direction.
// Anything seen while the run bit is low is dropped, never stored.
module dma_trig_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hw_hit_i,
    input  logic hw_dir_tx_i,
    input  logic sw_go_i,
    output logic req_o,
    output logic dir_tx_o
);
    logic req_q;
    logic dir_q;

    // Register the gated request and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            req_q <= run_i & (hw_hit_i | sw_go_i);
            dir_q <= run_i & hw_hit_i & hw_dir_tx_i;
        end
    end

    assign req_o    = req_q;
    assign dir_tx_o = dir_q;

    // R6: program mode in one cycle means no request in the next.
    a_r6_prog_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !req_o);

    // R9: a direction flag never appears without a request.
    a_r9_dir_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx_o |-> req_o);
endmodule

// File: rtl/dma_trig_sel.sv
// DMA channel trigger selector (top).
// Builds the edge lanes from the raw interrupt bus, picks channel 1's lane
// by select code, sends serial port 2 activity straight to channel 2 and
// gates both channels with their run bits.
// Assumes all inputs are synchronous to clk and the software strobes last
// one cycle.
module dma_trig_sel
    import dma_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ch1_src_sel_i,
    input  logic             ch1_run_i,
    input  logic             ch2_run_i,
    input  logic [IRQ_W-1:0] irq_i,
    input  logic [1:0]       sw_go_i,
    output logic             ch1_req_o,
    output logic             ch1_dir_tx_o,
    output logic             ch2_req_o,
    output logic             ch2_dir_tx_o
);
    logic [LANES-1:0] lane_lvl;
    logic [LANES-1:0] lane_rise;
    logic             ch1_hit;
    logic             ch1_dir;
    logic             ch2_hit;
    logic             ch2_dir;

    // Map the raw lines onto lanes; the serial port 2 tx/rx pair merges into one lane.
    always_comb begin
        lane_lvl[LN_U2]     = irq_i[IRQ_U2_TX] | irq_i[IRQ_U2_RX];
        lane_lvl[LN_TICK1A] = irq_i[IRQ_TICK1A];
        lane_lvl[LN_U1_RX]  = irq_i[IRQ_U1_RX];
        lane_lvl[LN_PLL]    = irq_i[IRQ_PLL];
        lane_lvl[LN_EXT2]   = irq_i[IRQ_EXT2];
        lane_lvl[LN_TICK2A] = irq_i[IRQ_TICK2A];
        lane_lvl[LN_U1_TX]  = irq_i[IRQ_U1_TX];
    end

    dma_trig_edge #(.W(LANES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lane_lvl),
        .rise_o (lane_rise)
    );

    dma_trig_ch1_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (ch1_src_sel_i),
        .rise_i      (lane_rise),
        .u2_tx_lvl_i (irq_i[IRQ_U2_TX]),
        .hit_o       (ch1_hit),
        .dir_tx_o    (ch1_dir)
    );

    // Channel 2 is hard-wired to the serial port 2 lane.
    always_comb begin
        ch2_hit = lane_rise[LN_U2];
        ch2_dir = lane_rise[LN_U2] & irq_i[IRQ_U2_TX];
    end

    dma_trig_chan u_ch1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (ch1_run_i),
        .hw_hit_i    (ch1_hit),
        .hw_dir_tx_i (ch1_dir),
        .sw_go_i     (sw_go_i[0]),
        .req_o       (ch1_req_o),
        .dir_tx_o    (ch1_dir_tx_o)
    );

    dma_trig_chan u_ch2 (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (ch2_run_i),
        .hw_hit_i    (ch2_hit),
        .hw_dir_tx_i (ch2_dir),
        .sw_go_i     (sw_go_i[1]),
        .req_o       (ch2_req_o),
        .dir_tx_o    (ch2_dir_tx_o)
    );

    // R4: a channel 2 hardware hit needs serial port 2 activity.
    a_r4_ch2_only_u2: assert property (@(posedge clk) disable iff (!rst_n)
        ch2_hit |-> (irq_i[IRQ_U2_TX] | irq_i[IRQ_U2_RX]));

    // R8: with no lane rising, channel 1 sees no hardware hit, whatever the select code does.
    a_r8_no_hit_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_rise == '0) |-> !ch1_hit);
endmodule

// File: tb/dma_trig_sel_bench.sv
module dma_trig_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] sel;
    logic       run1, run2;
    logic [7:0] irq;
    logic [1:0] sw;
    logic       req1, dir1, req2, dir2;

    int applied = 0;
    int bad     = 0;

    always #10 clk = ~clk;

    dma_trig_sel u_dma_trig_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .ch1_src_sel_i (sel),
        .ch1_run_i     (run1),
        .ch2_run_i     (run2),
        .irq_i         (irq),
        .sw_go_i       (sw),
        .ch1_req_o     (req1),
        .ch1_dir_tx_o  (dir1),
        .ch2_req_o     (req2),
        .ch2_dir_tx_o  (dir2)
    );

    typedef struct packed {
        logic [3:0] sel;
        logic       run1;
        logic       run2;
        logic [7:0] irq;
        logic [1:0] sw;
        logic       r1;
        logic       r2;
        logic       d1;
        logic       d2;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'b0011, 1'b1, 1'b1, 8'h01, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'd2},  // R2 u2 tx, R9
        '{4'b0011, 1'b1, 1'b1, 8'h02, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 u2 rx
        '{4'b0101, 1'b1, 1'b1, 8'h04, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 tick1a
        '{4'b0111, 1'b1, 1'b1, 8'h08, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 u1 rx
        '{4'b1001, 1'b1, 1'b1, 8'h10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 pll
        '{4'b1011, 1'b1, 1'b1, 8'h20, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 ext2
        '{4'b1101, 1'b1, 1'b1, 8'h40, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 tick2a
        '{4'b1111, 1'b1, 1'b1, 8'h80, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'd2},  // R2 u1 tx, R9
        '{4'b0111, 1'b1, 1'b1, 8'h80, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 wrong source
        '{4'b0100, 1'b1, 1'b1, 8'hFC, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 even code
        '{4'b0001, 1'b1, 1'b1, 8'hFC, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 code 0001
        '{4'b0101, 1'b1, 1'b1, 8'h01, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'd4},  // R4 ch2 ignores select
        '{4'b0011, 1'b0, 1'b1, 8'h01, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'd6},  // R6 ch1 in program mode
        '{4'b0011, 1'b1, 1'b0, 8'h02, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 ch2 in program mode
        '{4'b0000, 1'b1, 1'b1, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 software both
        '{4'b0000, 1'b0, 1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 software dropped
        '{4'b0011, 1'b1, 1'b1, 8'h03, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'd9}   // R9 tx wins
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp, input string what);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic e1, input logic e2,
                             input logic f1, input logic f2);
        check(req, req1, e1, "ch1_req");
        check(req, req2, e2, "ch2_req");
        check(req, dir1, f1, "ch1_dir");
        check(req, dir2, f2, "ch2_dir");
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel = 4'b0011; run1 = 1'b1; run2 = 1'b1;
        irq = 8'hFF; sw = 2'b11;
        @(negedge clk);
        step();
        check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);  // R1 quiet while in reset
        irq = 8'h00; sw = 2'b00;
        step();
        rst_n = 1'b1;
        step();
        check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);  // R1 first cycle after release

        // Table walk: apply a vector, check one cycle later, then drop every line.
        for (int i = 0; i < NV; i++) begin
            sel = VECS[i].sel; run1 = VECS[i].run1; run2 = VECS[i].run2;
            irq = VECS[i].irq; sw = VECS[i].sw;
            step();
            check_all($sformatf("R%0d", VECS[i].tag), VECS[i].r1, VECS[i].r2, VECS[i].d1, VECS[i].d2);
            irq = 8'h00; sw = 2'b00; run1 = 1'b1; run2 = 1'b1;
            step();
        end

        // R5: a held line gives one pulse; re-arming needs a fall.
        sel = 4'b1001; irq = 8'h10;
        step(); check("R5", req1, 1'b1, "held first");
        step(); check("R5", req1, 1'b0, "held second");
        step(); check("R5", req1, 1'b0, "held third");
        irq = 8'h00; step();
        irq = 8'h10; step(); check("R5", req1, 1'b1, "re-raised");
        irq = 8'h00; step();

        // R6: raising the run bit under a line that is already high stays silent.
        run1 = 1'b0; irq = 8'h10;
        step(); check("R6", req1, 1'b0, "program mode edge");
        run1 = 1'b1;
        step(); check("R6", req1, 1'b0, "run set, line high");
        step(); check("R6", req1, 1'b0, "run set, later");
        irq = 8'h00; step();

        // R8: switching the select code onto a line that is already high makes no request.
        sel = 4'b1001; irq = 8'h20;
        step(); check("R8", req1, 1'b0, "unselected rise");
        sel = 4'b1011;
        step(); check("R8", req1, 1'b0, "select change");
        step(); check("R8", req1, 1'b0, "select change later");
        irq = 8'h00; step();

        // R7: one strobe, one pulse.
        sw = 2'b01;
        step(); check("R7", req1, 1'b1, "strobe pulse");
        check("R7", req2, 1'b0, "other channel");
        sw = 2'b00;
        step(); check("R7", req1, 1'b0, "after strobe");

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule